// File: doc/BRIEF.md
# Platform-level interrupt controller core

This block collects up to 32 level-sensitive external interrupt lines and distributes them to two processor contexts. Context 0 serves machine-level software and context 1 serves supervisor-level software. Each source has a programmable 3-bit priority. Each context has its own enable mask and its own priority threshold. For each context the block continuously picks the best source that is pending, enabled for that context and above that context's threshold. It raises that context's interrupt line while such a source exists.

Software takes an interrupt by reading the context's claim/complete register. The read returns the winning source ID and removes that source from the pending set. The source then stays blocked until software writes the same ID back to the claim/complete register. All registers sit behind a word-wide valid/ready request bus. Every accepted request gets one response on the following cycle, and that response carries an error flag for accesses that are not allowed.

Top module: `irq_hub`

## Requirements
- R1: After reset, every priority, enable and threshold register reads 0, the pending word reads 0, both claim registers read 0, and both `irq_o` bits are low.
- R2: The priority of source k is at byte offset 4*k and holds the low 3 bits of the written data. Source 0 always reads 0, and writes to it have no effect.
- R3: The pending word is at offset 0x001000, with bit k standing for source k. A high source sets its bit one cycle after it is sampled. Bit 0 never sets. Writes to the pending word are accepted with no effect.
- R4: The enable words are at 0x002000 for context 0 and at 0x002080 for context 1, with bit k enabling source k. Bit 0 always reads 0. The two contexts are independent.
- R5: The threshold is at 0x200000 for context 0 and at 0x201000 for context 1, and it keeps 3 bits. A source takes part in a context only if its priority is strictly greater than that context's threshold.
- R6: `irq_o[c]` is a register. It is high exactly one cycle after a cycle in which some source is pending, enabled for c and above c's threshold.
- R7: A read of the claim register (0x200004 for context 0, 0x201004 for context 1) returns the ID of the eligible source with the highest priority. On a tie the lower ID wins. The read returns 0 when no source is eligible.
- R8: A claim read that returns ID k clears pending bit k. Source k then cannot become pending again, even while its input stays high, until it is completed.
- R9: Writing ID k to a context's claim register completes k only if k is enabled for that context. After a completion, a still-high source k becomes pending again one cycle later. A completion from a context where k is disabled is ignored.
- R10: The access size code 2 means 32 bits. Any other size, an address with bits [1:0] not 00, or an unmapped offset gives `rsp_err_o`=1 and `rsp_rdata_o`=0, and the access changes no state. Unmapped offsets include priorities at or above source 32, offsets 0x001004, 0x002004 and 0x200008, context windows beyond context 1, and gaps such as 0x100000.
- R11: `req_ready_o` is always high. Every accepted request produces `rsp_valid_o` for exactly one cycle on the next cycle, and no response is produced without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt sources, bit k is source k (bit 0 unused) |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 24 | Byte offset of the register |
| req_size_i | input | 2 | Access size code, 2 = 32-bit |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_rdata_o | output | 32 | Read data, 0 on writes and errors |
| rsp_err_o | output | 1 | Access error |
| irq_o | output | 2 | Interrupt line per context |

## Verification
Corrupt pending or in-flight state shows up at the ports in two ways. It either wrongly raises or drops an `irq_o` bit one cycle later, or it makes the next claim read return a wrong or repeated ID. A gateway that re-arms early shows as a pending bit reappearing on the next pending-word read after a claim, while the source is still held high. A bad arbitration order or a wrong threshold comparison shows on the very next claim response. A decode fault shows as a wrong `rsp_err_o` on the response cycle, or as a register that has been changed by a rejected access.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  localparam logic [1:0]  SIZE_WORD  = 2'd2;
  localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
  localparam logic [31:0] THR_OFF    = 32'h0000_0000;
  localparam logic [31:0] CLAIM_OFF  = 32'h0000_0004;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_PEND,
    RK_EN,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
  import irq_hub_pkg::*;
#(
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CTX = 2,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC),
  localparam int unsigned CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output reg_kind_e         kind_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic              err_o
);

  logic [31:0] addr_w;
  logic [31:0] rel_en;
  logic [31:0] rel_ctx;
  reg_kind_e   kind;

  always_comb begin
    addr_w  = 32'(addr_i);
    rel_en  = addr_w - EN_BASE;
    rel_ctx = addr_w - CTX_BASE;
    kind    = RK_NONE;
    src_o   = '0;
    ctx_o   = '0;
    if (addr_w < NUM_SRC * 4) begin
      kind  = RK_PRIO;
      src_o = SRC_W'(addr_w >> 2);
    end else if (addr_w == PEND_BASE) begin
      kind = RK_PEND;
    end else if (addr_w >= EN_BASE && rel_en < NUM_CTX * EN_STRIDE) begin
      ctx_o = CTX_W'(rel_en / EN_STRIDE);
      if ((rel_en % EN_STRIDE) == 32'd0) kind = RK_EN;
    end else if (addr_w >= CTX_BASE && rel_ctx < NUM_CTX * CTX_STRIDE) begin
      ctx_o = CTX_W'(rel_ctx / CTX_STRIDE);
      if ((rel_ctx % CTX_STRIDE) == THR_OFF)        kind = RK_THR;
      else if ((rel_ctx % CTX_STRIDE) == CLAIM_OFF) kind = RK_CLAIM;
    end
    err_o  = (kind == RK_NONE) || (size_i != SIZE_WORD) || (addr_w[1:0] != 2'b00);
    kind_o = err_o ? RK_NONE : kind;
  end

endmodule

// File: rtl/irq_hub_gateway.sv
module irq_hub_gateway (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o,
  output logic busy_o
);

  logic pend_q;
  logic busy_q;

  // claim takes priority; a busy source cannot re-latch until completed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (claim_i) begin
      pend_q <= 1'b0;
      busy_q <= 1'b1;
    end else if (complete_i) begin
      busy_q <= 1'b0;
    end else if (src_i && !busy_q) begin
      pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;

endmodule

// File: rtl/irq_hub_arbiter.sv
module irq_hub_arbiter #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned PRIO_W  = 3,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC-1:0]        en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic [SRC_W-1:0]          id_o,
  output logic                      hit_o
);

  logic [PRIO_W-1:0] cur_p;
  logic [PRIO_W-1:0] best_p;

  // ascending scan with strict compare: lower ID keeps ties
  always_comb begin
    id_o   = '0;
    best_p = '0;
    cur_p  = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      cur_p = prio_i[i*PRIO_W +: PRIO_W];
      if (pend_i[i] && en_i[i] && (cur_p > thr_i) && (cur_p > best_p)) begin
        best_p = cur_p;
        id_o   = SRC_W'(i);
      end
    end
    hit_o = (id_o != '0);
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC),
  localparam int unsigned CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_write_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_size_i,
  input  logic [DATA_W-1:0]  req_wdata_i,
  output logic               rsp_valid_o,
  output logic [DATA_W-1:0]  rsp_rdata_o,
  output logic               rsp_err_o,
  output logic [NUM_CTX-1:0] irq_o
);

  localparam logic [NUM_SRC-1:0] SRC_MASK = {{(NUM_SRC-1){1'b1}}, 1'b0};

  reg_kind_e          dec_kind;
  logic [SRC_W-1:0]   dec_src;
  logic [CTX_W-1:0]   dec_ctx;
  logic               dec_err;
  logic               acc, wr_ok, rd_ok;

  logic [PRIO_W-1:0]  prio_q [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SRC-1:0] en_q   [NUM_CTX];
  logic [PRIO_W-1:0]  thr_q  [NUM_CTX];

  logic [NUM_SRC-1:0] pend_vec, busy_vec, claim_vec, cmp_vec, src_act;
  logic [SRC_W-1:0]   win_id [NUM_CTX];
  logic [NUM_CTX-1:0] win_hit;

  logic               claim_any, cmp_any;
  logic [SRC_W-1:0]   cmp_id;
  logic [DATA_W-1:0]  rd_data;

  logic               rsp_valid_q, rsp_err_q;
  logic [DATA_W-1:0]  rsp_rdata_q;
  logic [NUM_CTX-1:0] irq_q;

  assign req_ready_o = 1'b1;
  assign acc   = req_valid_i && req_ready_o;
  assign wr_ok = acc && req_write_i && !dec_err;
  assign rd_ok = acc && !req_write_i && !dec_err;

  irq_hub_decode #(
    .ADDR_W (ADDR_W),
    .NUM_SRC(NUM_SRC),
    .NUM_CTX(NUM_CTX)
  ) u_dec (
    .addr_i(req_addr_i),
    .size_i(req_size_i),
    .kind_o(dec_kind),
    .src_o (dec_src),
    .ctx_o (dec_ctx),
    .err_o (dec_err)
  );

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SRC; s++) prio_q[s] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (wr_ok) begin
      for (int s = 1; s < NUM_SRC; s++)
        if (dec_kind == RK_PRIO && dec_src == SRC_W'(s))
          prio_q[s] <= req_wdata_i[PRIO_W-1:0];
      for (int c = 0; c < NUM_CTX; c++) begin
        if (dec_kind == RK_EN && dec_ctx == CTX_W'(c))
          en_q[c] <= req_wdata_i[NUM_SRC-1:0] & SRC_MASK;
        if (dec_kind == RK_THR && dec_ctx == CTX_W'(c))
          thr_q[c] <= req_wdata_i[PRIO_W-1:0];
      end
    end
  end

  // claim / complete
  assign claim_any = rd_ok && (dec_kind == RK_CLAIM) && win_hit[dec_ctx];
  assign claim_vec = claim_any ? (NUM_SRC'(1) << win_id[dec_ctx]) : '0;
  assign cmp_id    = req_wdata_i[SRC_W-1:0];
  assign cmp_any   = wr_ok && (dec_kind == RK_CLAIM)
                   && (req_wdata_i[DATA_W-1:SRC_W] == '0)
                   && (32'(cmp_id) < NUM_SRC)
                   && en_q[dec_ctx][cmp_id];
  assign cmp_vec   = cmp_any ? (NUM_SRC'(1) << cmp_id) : '0;
  assign src_act   = src_i & SRC_MASK;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
    irq_hub_gateway u_gw (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_act[g]),
      .claim_i   (claim_vec[g]),
      .complete_i(cmp_vec[g]),
      .pend_o    (pend_vec[g]),
      .busy_o    (busy_vec[g])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_hub_arbiter #(
      .NUM_SRC(NUM_SRC),
      .PRIO_W (PRIO_W)
    ) u_arb (
      .pend_i(pend_vec),
      .en_i  (en_q[c]),
      .prio_i(prio_flat),
      .thr_i (thr_q[c]),
      .id_o  (win_id[c]),
      .hit_o (win_hit[c])
    );
  end

  // read mux
  always_comb begin
    rd_data = '0;
    unique case (dec_kind)
      RK_PRIO:  rd_data[PRIO_W-1:0]  = prio_q[dec_src];
      RK_PEND:  rd_data[NUM_SRC-1:0] = pend_vec;
      RK_EN:    rd_data[NUM_SRC-1:0] = en_q[dec_ctx];
      RK_THR:   rd_data[PRIO_W-1:0]  = thr_q[dec_ctx];
      RK_CLAIM: rd_data[SRC_W-1:0]   = win_id[dec_ctx];
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= '0;
      irq_q       <= '0;
    end else begin
      rsp_valid_q <= acc;
      rsp_err_q   <= acc && dec_err;
      rsp_rdata_q <= rd_ok ? rd_data : '0;
      irq_q       <= win_hit;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_err_o   = rsp_err_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign irq_o       = irq_q;

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
  import irq_hub_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_CTX = 2,
  parameter int unsigned ADDR_W  = 24,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               req_write_i,
  input logic [ADDR_W-1:0]  req_addr_i,
  input logic [1:0]         req_size_i,
  input logic               rsp_valid_o,
  input logic [DATA_W-1:0]  rsp_rdata_o,
  input logic               rsp_err_o,
  input logic [NUM_CTX-1:0] irq_o,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] busy_i
);

  logic claim_rd;
  assign claim_rd = req_valid_i && !req_write_i && (req_size_i == SIZE_WORD)
                 && ((32'(req_addr_i) == CTX_BASE + CLAIM_OFF)
                  || (32'(req_addr_i) == CTX_BASE + CTX_STRIDE + CLAIM_OFF));

  AST_SRC0_NEVER_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i[0]); // R3

  AST_PEND_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i & busy_i) == '0); // R8

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o); // R11

  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !rsp_valid_o); // R11

  AST_SIZE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_size_i != SIZE_WORD) |=> rsp_err_o); // R10

  AST_ALIGN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[1:0] != 2'b00) |=> rsp_err_o); // R10

  AST_ERR_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_rdata_o == '0)); // R10

  AST_CLAIM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o && $past(claim_rd) && rsp_rdata_o != '0)
      |-> (!pend_i[rsp_rdata_o[SRC_W-1:0]] && busy_i[rsp_rdata_o[SRC_W-1:0]])); // R8

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> $past(pend_i != '0)); // R6

endmodule

bind irq_hub irq_hub_chk #(
  .NUM_SRC(NUM_SRC),
  .NUM_CTX(NUM_CTX),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_size_i (req_size_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_rdata_o(rsp_rdata_o),
  .rsp_err_o  (rsp_err_o),
  .irq_o      (irq_o),
  .pend_i     (pend_vec),
  .busy_i     (busy_vec)
);

// File: tb/irq_hub_tb.sv
module irq_hub_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic [1:0]  irq;

  always #5 clk = ~clk;

  irq_hub u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .src_i      (src),
    .req_valid_i(req_valid),
    .req_ready_o(req_ready),
    .req_write_i(req_write),
    .req_addr_i (req_addr),
    .req_size_i (req_size),
    .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata),
    .rsp_err_o  (rsp_err),
    .irq_o      (irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic        wr;
    logic [23:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        err;
    logic [31:0] rdata;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 24'h000014, 2'd2, 32'h0,        1'b0, 32'h0,        8'd1},  // R1
    '{1'b0, 24'h002000, 2'd2, 32'h0,        1'b0, 32'h0,        8'd1},  // R1
    '{1'b0, 24'h201000, 2'd2, 32'h0,        1'b0, 32'h0,        8'd1},  // R1
    '{1'b0, 24'h200004, 2'd2, 32'h0,        1'b0, 32'h0,        8'd1},  // R1
    '{1'b1, 24'h000014, 2'd2, 32'hFF,       1'b0, 32'h0,        8'd2},  // R2
    '{1'b0, 24'h000014, 2'd2, 32'h0,        1'b0, 32'h7,        8'd2},  // R2
    '{1'b1, 24'h000000, 2'd2, 32'h5,        1'b0, 32'h0,        8'd2},  // R2
    '{1'b0, 24'h000000, 2'd2, 32'h0,        1'b0, 32'h0,        8'd2},  // R2
    '{1'b1, 24'h002000, 2'd2, 32'hFFFFFFFF, 1'b0, 32'h0,        8'd4},  // R4
    '{1'b0, 24'h002000, 2'd2, 32'h0,        1'b0, 32'hFFFFFFFE, 8'd4},  // R4
    '{1'b1, 24'h002080, 2'd2, 32'hF0,       1'b0, 32'h0,        8'd4},  // R4
    '{1'b0, 24'h002080, 2'd2, 32'h0,        1'b0, 32'hF0,       8'd4},  // R4
    '{1'b0, 24'h002000, 2'd2, 32'h0,        1'b0, 32'hFFFFFFFE, 8'd4},  // R4
    '{1'b1, 24'h200000, 2'd2, 32'hA,        1'b0, 32'h0,        8'd5},  // R5
    '{1'b0, 24'h200000, 2'd2, 32'h0,        1'b0, 32'h2,        8'd5},  // R5
    '{1'b1, 24'h201000, 2'd2, 32'h3,        1'b0, 32'h0,        8'd5},  // R5
    '{1'b0, 24'h201000, 2'd2, 32'h0,        1'b0, 32'h3,        8'd5},  // R5
    '{1'b1, 24'h001000, 2'd2, 32'hFFFFFFFF, 1'b0, 32'h0,        8'd3},  // R3
    '{1'b0, 24'h001000, 2'd2, 32'h0,        1'b0, 32'h0,        8'd3},  // R3
    '{1'b0, 24'h000014, 2'd1, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b1, 24'h000014, 2'd0, 32'h1,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 24'h000014, 2'd2, 32'h0,        1'b0, 32'h7,        8'd10}, // R10
    '{1'b0, 24'h000016, 2'd2, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 24'h000080, 2'd2, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 24'h001004, 2'd2, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 24'h002004, 2'd2, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 24'h200008, 2'd2, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 24'h202000, 2'd2, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b1, 24'h100000, 2'd2, 32'h1,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 24'h002100, 2'd2, 32'h0,        1'b1, 32'h0,        8'd10}, // R10
    '{1'b0, 24'h000017, 2'd2, 32'h0,        1'b1, 32'h0,        8'd10}  // R10
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [23:0] addr, input logic [1:0] size,
                     input logic [31:0] wdata, output logic [31:0] rdata, output logic err);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_size  = size;
    req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    rdata = rsp_rdata;
    err   = rsp_err;
    check("R11 rsp_valid", 32'(rsp_valid), 32'h1);
  endtask

  task automatic wr(input logic [23:0] addr, input logic [31:0] data);
    logic [31:0] rd;
    logic        e;
    bus(1'b1, addr, 2'd2, data, rd, e);
  endtask

  task automatic rd_chk(input string tag, input logic [23:0] addr, input logic [31:0] exp);
    logic [31:0] rd;
    logic        e;
    bus(1'b0, addr, 2'd2, 32'h0, rd, e);
    check(tag, rd, exp);
  endtask

  task automatic do_reset();
    src   = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        e;
    do_reset();
    check("R1 irq after reset", 32'(irq), 32'h0);
    check("R11 ready", 32'(req_ready), 32'h1);

    for (int i = 0; i < NV; i++) begin
      bus(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, rd, e);
      checks++;
      if (e !== VECS[i].err || rd !== VECS[i].rdata) begin
        errors++;
        $display("FAIL R%0d vector %0d actual err %0b data %0h expected err %0b data %0h",
                 VECS[i].req, i, e, rd, VECS[i].err, VECS[i].rdata);
      end
    end
    @(negedge clk);
    check("R11 no response when idle", 32'(rsp_valid), 32'h0);

    // R6 / R3: single source, context 0 only
    do_reset();
    wr(24'h00000C, 32'd2);
    wr(24'h00001C, 32'd2);
    wr(24'h000024, 32'd5);
    wr(24'h002000, 32'h0000_0288);
    @(negedge clk);
    src[3] = 1'b1;
    @(negedge clk);
    check("R6 irq one cycle late", 32'(irq), 32'h0);
    @(negedge clk);
    check("R6 irq ctx0 high, ctx1 low", 32'(irq), 32'h1);
    rd_chk("R3 pending bit 3", 24'h001000, 32'h0000_0008);

    // R7 / R8: priority order, tie break, blocking
    src[7] = 1'b1;
    src[9] = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R7 highest priority wins", 24'h200004, 32'd9);
    rd_chk("R8 claim clears pending", 24'h001000, 32'h0000_0088);
    repeat (3) @(negedge clk);
    rd_chk("R8 claimed source stays blocked", 24'h001000, 32'h0000_0088);
    rd_chk("R7 tie lower id", 24'h200004, 32'd3);
    rd_chk("R7 next claim", 24'h200004, 32'd7);
    rd_chk("R7 empty claim", 24'h200004, 32'd0);
    @(negedge clk);
    check("R6 irq drops after claims", 32'(irq), 32'h0);

    // R9: completion rules
    wr(24'h200004, 32'd9);
    @(negedge clk);
    rd_chk("R9 completed source re-pends", 24'h001000, 32'h0000_0200);
    wr(24'h201004, 32'd3);
    repeat (2) @(negedge clk);
    rd_chk("R9 completion from disabled ctx ignored", 24'h001000, 32'h0000_0200);
    wr(24'h200004, 32'd3);
    @(negedge clk);
    rd_chk("R9 completion via ctx0", 24'h001000, 32'h0000_0208);

    // R5: inclusive threshold
    wr(24'h200000, 32'd5);
    @(negedge clk);
    check("R5 irq masked at equal threshold", 32'(irq), 32'h0);
    rd_chk("R5 claim masked", 24'h200004, 32'd0);
    wr(24'h200000, 32'd4);
    rd_chk("R5 claim above threshold", 24'h200004, 32'd9);
    rd_chk("R5 pending after claim", 24'h001000, 32'h0000_0008);

    // R4: context 1 independent of context 0
    wr(24'h002080, 32'h0000_0008);
    wr(24'h201000, 32'd1);
    @(negedge clk);
    check("R4 irq ctx1", 32'(irq[1]), 32'h1);
    rd_chk("R4 claim ctx1", 24'h201004, 32'd3);
    rd_chk("R4 pending empty", 24'h001000, 32'h0);
    @(negedge clk);
    check("R4 irq both low", 32'(irq), 32'h0);

    // R1: reset mid-operation
    do_reset();
    check("R1 irq after second reset", 32'(irq), 32'h0);
    rd_chk("R1 pending cleared", 24'h001000, 32'h0);
    rd_chk("R1 priority cleared", 24'h000024, 32'h0);
    rd_chk("R1 threshold cleared", 24'h200000, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule